// File: doc/BRIEF.md
# Real-Time Interrupt Timer with Watchdog

The block is a free-running binary divider driven by the operating clock. Two interrupt sources come from it. The first is an overflow event, raised each time the low eight divider stages wrap. The second is a periodic real-time event, raised on one of four divider taps chosen by a 2-bit rate field. Each source has a sticky flag and its own enable. Software reads and writes all of these through a single 8-bit control register. The flags can be set only by hardware. Software clears a flag by writing 0 to it, and writing 1 to a flag does nothing.

The real-time event also advances a 3-bit watchdog. Software must service the watchdog with a strobe. If the strobe does not come in time, the block emits a one-cycle reset pulse and returns the divider and the register to their reset state. The watchdog follows the selected tap, so changing the rate also changes the watchdog timeout.

Top module: `tmr_rti_top`

## Requirements
- R1: The overflow flag (register bit 7) sets on the clock edge where divider bits 7:0 wrap from 0xFF to 0x00. After reset this first happens at the 256th clock edge.
- R2: `ovf_irq` is 1 exactly when the overflow flag and the overflow enable (bit 5) are both 1.
- R3: The real-time flag (bit 6) sets on the edge after divider bit TAP_BASE-1+rate rises. The rate is in bits 1:0. The values 00, 01, 10 and 11 give a real-time period of 2^(TAP_BASE), 2^(TAP_BASE+1), 2^(TAP_BASE+2) and 2^(TAP_BASE+3) clocks.
- R4: `rti_irq` is 1 exactly when the real-time flag and the real-time enable (bit 4) are both 1.
- R5: On a write, a 0 in bit 7 or bit 6 clears that flag, and a 1 leaves the flag unchanged. Bits 5, 4 and 1:0 take the written value.
- R6: Register bits 3:2 always read 0.
- R7: Reset clears both flags and both enables and sets the rate to 11, so the register reads 0x03.
- R8: If a hardware set event and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R9: Each real-time event advances the watchdog counter. `wdg_kick` clears the counter and takes priority over an event in the same cycle. The eighth event without a kick is the timeout, which is between 7 and 8 real-time periods after the last kick.
- R10: On timeout, `wdg_rst` is 1 for exactly one cycle. In that same cycle the register reads 0x03 and the divider has restarted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| ovf_irq | output | 1 | Overflow interrupt request |
| rti_irq | output | 1 | Real-time interrupt request |
| wdg_kick | input | 1 | Watchdog service strobe |
| wdg_rst | output | 1 | Watchdog reset pulse |

## Verification
The bench runs random register writes with a fixed seed. These writes change the rate field while the divider is running, so a flag that fires on the wrong tap shows up against the bench model at every one of the four rates. Random enable values together with random flag clears show whether each request follows its own flag and its own enable and no other bit. One directed write times a clear to land exactly on the wrap edge, which shows whether set wins over clear. A second directed write puts ones into cleared flags, which separates "write 1 has no effect" from "write sets the flag". Finally the kicks are stopped at the fastest rate. This checks that the timeout lands on the eighth tick, that the reset pulse lasts one cycle, and that the register returns to its defaults.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int SEL_W     = 2;
    localparam int NUM_RATES = 1 << SEL_W;
    localparam int WDG_W     = 3;
    localparam int LOW_W     = 8;
    localparam int BIT_OVF   = 7;
    localparam int BIT_RTI   = 6;
    localparam int BIT_OVE   = 5;
    localparam int BIT_RTE   = 4;

    typedef struct packed {
        logic             ovf;
        logic             rti;
        logic             ove;
        logic             rte;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    localparam ctl_t CTL_DEFAULT = '{ovf: 1'b0, rti: 1'b0, ove: 1'b0,
                                     rte: 1'b0, sel: {SEL_W{1'b1}}};
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider
    import tmr_pkg::*;
#(
    parameter int TAP_BASE = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf_evt,
    output logic             tick
);
    localparam int DIV_W = TAP_BASE + NUM_RATES - 1;

    typedef struct packed {
        logic [DIV_W-1:0]     cnt;
        logic [NUM_RATES-1:0] prev;
    } div_st_t;

    div_st_t              st_d, st_q;
    logic [NUM_RATES-1:0] taps;

    for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_tap
        assign taps[gi] = st_q.cnt[TAP_BASE-1+gi];
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.prev = '0;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.prev = taps;
        end
        ovf_evt = &st_q.cnt[LOW_W-1:0];
        tick    = taps[sel] & ~st_q.prev[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: the low stages really wrap to zero after an overflow event
    a_r1_low_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (st_q.cnt[LOW_W-1:0] == '0));
    // R10: timeout restarts the divider
    a_r10_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ovf_evt,
    input  logic       rti_evt,
    output ctl_t       ctl,
    output logic [7:0] rd_data,
    output logic       ovf_irq,
    output logic       rti_irq
);
    ctl_t ctl_d, ctl_q;
    logic unused_bits;

    assign unused_bits = ^wr_data[3:2];

    always_comb begin
        ctl_d = ctl_q;
        if (clr) begin
            ctl_d = CTL_DEFAULT;
        end else begin
            if (wr_en) begin
                ctl_d.ove = wr_data[BIT_OVE];
                ctl_d.rte = wr_data[BIT_RTE];
                ctl_d.sel = wr_data[SEL_W-1:0];
            end
            ctl_d.ovf = ovf_evt | (ctl_q.ovf & ~(wr_en & ~wr_data[BIT_OVF]));
            ctl_d.rti = rti_evt | (ctl_q.rti & ~(wr_en & ~wr_data[BIT_RTI]));
        end
        rd_data = {ctl_q.ovf, ctl_q.rti, ctl_q.ove, ctl_q.rte, 2'b00, ctl_q.sel};
        ovf_irq = ctl_q.ovf & ctl_q.ove;
        rti_irq = ctl_q.rti & ctl_q.rte;
        ctl     = ctl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_DEFAULT;
        else        ctl_q <= ctl_d;
    end

    // R8: a set event is never lost to a clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !clr) |=> ctl_q.ovf);
    // R5: writing one keeps a set flag
    a_r5_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_RTI] && ctl_q.rti && !clr) |=> ctl_q.rti);
    // R5: writing zero clears when no event competes
    a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_OVF] && !ovf_evt && !clr) |=> !ctl_q.ovf);
    // R10: timeout restores register defaults
    a_r10_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_data == 8'h03));
endmodule

// File: rtl/tmr_watchdog.sv
module tmr_watchdog
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick,
    output logic timeout,
    output logic wdg_rst
);
    typedef struct packed {
        logic [WDG_W-1:0] cnt;
        logic             pulse;
    } wdg_st_t;

    wdg_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        timeout = tick & ~kick & (&st_q.cnt);
        if (kick || timeout) st_d.cnt = '0;
        else if (tick)       st_d.cnt = st_q.cnt + 1'b1;
        st_d.pulse = timeout;
        wdg_rst    = st_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: the reset pulse lasts one cycle
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst |=> !wdg_rst);
    // R9: a service strobe empties the counter
    a_r9_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (st_q.cnt == '0));
endmodule

// File: rtl/tmr_rti_top.sv
module tmr_rti_top
    import tmr_pkg::*;
#(
    parameter int TAP_BASE = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       ovf_irq,
    output logic       rti_irq,
    input  logic       wdg_kick,
    output logic       wdg_rst
);
    ctl_t ctl;
    logic ovf_evt;
    logic tick;
    logic timeout;

    tmr_divider #(.TAP_BASE(TAP_BASE)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (timeout),
        .sel     (ctl.sel),
        .ovf_evt (ovf_evt),
        .tick    (tick)
    );

    tmr_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (timeout),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ovf_evt (ovf_evt),
        .rti_evt (tick),
        .ctl     (ctl),
        .rd_data (rd_data),
        .ovf_irq (ovf_irq),
        .rti_irq (rti_irq)
    );

    tmr_watchdog i_wdg (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .kick    (wdg_kick),
        .timeout (timeout),
        .wdg_rst (wdg_rst)
    );
endmodule

// File: tb/test_tmr_rti_top.sv
module test_tmr_rti_top;
    localparam int TB = 10;
    localparam int CW = TB + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wdg_kick = 1'b0;
    logic [7:0] rd_data;
    logic       ovf_irq, rti_irq, wdg_rst;

    int  vectors = 0;
    int  fails = 0;
    bit  run = 1'b0;
    bit  done = 1'b0;

    logic [CW-1:0] m_cnt;
    logic          m_ovf, m_rti, m_ove, m_rte, m_wrst;
    logic [1:0]    m_sel;
    logic [2:0]    m_w;

    always #4 clk = ~clk;

    tmr_rti_top #(.TAP_BASE(TB)) i_tmr_rti_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ovf_irq(ovf_irq), .rti_irq(rti_irq),
        .wdg_kick(wdg_kick), .wdg_rst(wdg_rst)
    );

    function automatic bit rti_event(logic [CW-1:0] c, logic [1:0] s);
        int k = TB - 1 + int'(s);
        logic [CW-1:0] low = c & CW'((1 << k) - 1);
        return c[k] && (low == '0);
    endfunction

    function automatic logic [7:0] exp_reg();
        return {m_ovf, m_rti, m_ove, m_rte, 2'b00, m_sel};
    endfunction

    task automatic model_defaults();
        m_cnt = '0; m_ovf = 0; m_rti = 0; m_ove = 0; m_rte = 0;
        m_sel = 2'b11; m_w = '0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_defaults();
            m_wrst = 0;
        end else begin
            bit oe, re, to;
            oe = (m_cnt[7:0] == 8'hFF);
            re = rti_event(m_cnt, m_sel);
            to = re && !wdg_kick && (m_w == 3'd7);
            m_wrst = to;
            if (to) begin
                model_defaults();
            end else begin
                m_ovf = oe | (m_ovf & ~(wr_en & ~wr_data[7]));
                m_rti = re | (m_rti & ~(wr_en & ~wr_data[6]));
                if (wr_en) begin
                    m_ove = wr_data[5]; m_rte = wr_data[4]; m_sel = wr_data[1:0];
                end
                if (wdg_kick) m_w = '0;
                else if (re)  m_w = m_w + 3'd1;
                m_cnt = m_cnt + 1'b1;
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run && rst_n) begin
            chk("R1 overflow flag", {7'd0, rd_data[7]}, {7'd0, m_ovf});
            chk("R3 real-time flag", {7'd0, rd_data[6]}, {7'd0, m_rti});
            chk("R2 overflow request", {7'd0, ovf_irq}, {7'd0, m_ovf & m_ove});
            chk("R4 real-time request", {7'd0, rti_irq}, {7'd0, m_rti & m_rte});
            chk("R5 enables and rate", {rd_data[5:4], 4'd0, rd_data[1:0]},
                {m_ove, m_rte, 4'd0, m_sel});
            chk("R6 unused bits", {6'd0, rd_data[3:2]}, 8'd0);
            chk("R9 watchdog pulse", {7'd0, wdg_rst}, {7'd0, m_wrst});
        end
    end

    task automatic write_reg(logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        int pulses;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R7 reset register", rd_data, 8'h03);
        chk("R7 reset requests", {6'd0, ovf_irq, rti_irq}, 8'd0);
        chk("R7 reset pulse", {7'd0, wdg_rst}, 8'd0);
        rst_n = 1'b1;
        run = 1'b1;
        // R1: the first wrap comes after 256 edges
        repeat (255) @(negedge clk);
        chk("R1 no flag before wrap", {7'd0, rd_data[7]}, 8'd0);
        @(negedge clk);
        chk("R1 flag at wrap", {7'd0, rd_data[7]}, 8'd1);

        for (int i = 0; i < 60000; i++) begin
            wr_en    = ($urandom % 40) == 0;
            wr_data  = 8'($urandom);
            wdg_kick = ($urandom % 300) == 0;
            @(negedge clk);
        end
        wr_en = 0; wdg_kick = 0;

        // R8: clear lands on the wrap edge
        while (m_cnt[7:0] != 8'hFF) @(negedge clk);
        write_reg(8'h43);
        chk("R8 set beats clear", {7'd0, rd_data[7]}, 8'd1);

        // R5: writing ones into cleared flags has no effect
        while (m_cnt[7:0] > 8'hE0 || rti_event(m_cnt + 1'b1, m_sel)
               || rti_event(m_cnt + 2'd2, m_sel)) @(negedge clk);
        write_reg(8'h03);
        write_reg(8'hC3);
        chk("R5 write one ignored", {6'd0, rd_data[7:6]}, 8'd0);
        write_reg(8'hFF);
        chk("R6 unused after ones", {6'd0, rd_data[3:2]}, 8'd0);

        // R10: stop kicking at the fastest rate
        wdg_kick = 1'b1;
        write_reg(8'h00);
        wdg_kick = 1'b0;
        pulses = 0;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if (wdg_rst) begin
                pulses++;
                chk("R10 defaults at pulse", rd_data, 8'h03);
                if (i < 7 * 1024 || i > 8 * 1024 + 2) begin
                    fails++;
                    $display("FAIL R9 timeout window actual=%0d expected=7168..8194", i);
                end
            end
        end
        chk("R10 single pulse", 8'(pulses), 8'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule